// File: doc/BRIEF.md
# Byte-Serial Counter Register Front End

This block is the host-facing register front end of a single 24-bit counter channel. The host sees two 8-bit locations: a data location and a control/status location. Writing the control location either stores a small configuration field or issues reset and load commands toward the counter core. Which of these happens depends on a two-bit target select field. Reading the control location returns the channel's status flags.

Wide values move one byte at a time. A shared three-position byte pointer steps through the 24-bit preset register on data writes and through the 24-bit output latch on data reads. Bytes go least significant first, and the pointer wraps after the third byte. The counter arithmetic lives elsewhere. This block drives it with one-cycle command pulses, the preset value, an 8-bit filter prescaler value and three 5-bit configuration fields. The only way to give the counter a new value is to load the preset register and then issue a preset-to-counter transfer.

Host accesses arrive on a valid/ready request channel. Read results leave on a valid/ready response channel. `host_ready` is low while a response is waiting, so at most one read is in flight. A response stays valid, with constant data, until `rsp_ready` is seen high at a clock edge.

Top module: `cnt_byte_fe`

## Requirements
- R1: After reset, `preset`, `psc`, `mode_cfg`, `io_cfg`, `idx_cfg`, the output latch and the byte pointer are zero. No command pulse is high, `rsp_valid` is low and `host_ready` is high.
- R2: A control write whose bits 6:5 are 1, 2 or 3 stores byte bits 4:0 into `mode_cfg`, `io_cfg` or `idx_cfg` respectively. The other two fields are left unchanged.
- R3: A control write with bits 6:5 equal to 0 and bit 0 set returns the byte pointer to byte 0.
- R4: In a command byte (bits 6:5 = 0), bits 2:1 = 2 give a one-cycle `clr_flags` pulse, and bits 2:1 = 3 give a one-cycle `clr_err` pulse. Values 0 and 1 give neither pulse.
- R5: In a command byte, bits 4:3 = 1 give a one-cycle `load_cnt` pulse. The pulse is high in the cycle after the accepted write.
- R6: In a command byte, bits 4:3 = 2 copy `core_count`, as sampled at the accepting edge, into the output latch. Without this command, the latch ignores `core_count`.
- R7: In a command byte, bits 4:3 = 3 copy preset bits 7:0 into `psc`.
- R8: Each data write stores its byte into preset byte [pointer] and then advances the pointer. After byte 2 the pointer goes back to byte 0.
- R9: Each data read returns output latch byte [pointer] and then advances the pointer, with the same wrap.
- R10: A control read returns the status byte {2'b00, `core_up`, `core_err`, `core_flags[3:0]`}. This places the error flag at bit 4 and the up/down flag at bit 5.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high, `rsp_data` is unchanged and `host_ready` is low.
- R12: A control write with bits 6:5 not equal to 0 produces no command pulse and changes neither the pointer, the latch nor `psc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Request accepted when high together with valid |
| host_write | input | 1 | 1 = write, 0 = read |
| host_ctl | input | 1 | 1 = control/status location, 0 = data location |
| host_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read result valid |
| rsp_ready | input | 1 | Host takes the read result |
| rsp_data | output | 8 | Read result byte |
| core_count | input | 24 | Live counter value from the core |
| core_flags | input | 4 | Low status flags from the core |
| core_err | input | 1 | Error flag from the core |
| core_up | input | 1 | Up/down flag from the core (1 = up) |
| preset | output | 24 | Preset register |
| psc | output | 8 | Filter prescaler value |
| load_cnt | output | 1 | Pulse: transfer preset to counter |
| clr_flags | output | 1 | Pulse: clear borrow, carry, compare, sign and index flags |
| clr_err | output | 1 | Pulse: clear error flag |
| mode_cfg | output | 5 | Counter mode field |
| io_cfg | output | 5 | I/O control field |
| idx_cfg | output | 5 | Index control field |

## Verification
Every accepted write takes effect at its accepting edge. Preset, latch, prescaler, configuration fields and pointer show the new value one cycle after the handshake, and the command pulses are high for exactly that one cycle. A read result appears on `rsp_data` one cycle after the accepting edge and holds until it is taken. The bench drives each access on a falling edge and samples on the next falling edge after the accepting edge, which is where every result is first due. Each pulse is checked again one cycle later, to confirm it has dropped.

// File: rtl/cnt_fe_pkg.sv
package cnt_fe_pkg;

  // Control byte layout
  localparam int SEL_LO  = 5;
  localparam int SEL_HI  = 6;
  localparam int CFG_W   = 5;

  typedef enum logic [1:0] {
    TGT_CMD  = 2'd0,
    TGT_MODE = 2'd1,
    TGT_IO   = 2'd2,
    TGT_IDX  = 2'd3
  } tgt_e;

  typedef struct packed {
    logic ptr_clr;
    logic clr_flags;
    logic clr_err;
    logic ld_cnt;
    logic lat_cnt;
    logic ld_psc;
    logic wr_mode;
    logic wr_io;
    logic wr_idx;
  } ctl_cmd_t;

endpackage

// File: rtl/cfe_ctl_decode.sv
module cfe_ctl_decode
  import cnt_fe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              en,
  input  logic [DATA_W-1:0] cbyte,
  output ctl_cmd_t          cmd
);

  tgt_e       tgt;
  logic [1:0] rs_fld;
  logic [1:0] ld_fld;

  assign tgt    = tgt_e'(cbyte[SEL_HI:SEL_LO]);
  assign rs_fld = cbyte[2:1];
  assign ld_fld = cbyte[4:3];

  always_comb begin
    cmd = '0;
    if (en) begin
      unique case (tgt)
        TGT_CMD: begin
          cmd.ptr_clr   = cbyte[0];
          cmd.clr_flags = (rs_fld == 2'd2);
          cmd.clr_err   = (rs_fld == 2'd3);
          cmd.ld_cnt    = (ld_fld == 2'd1);
          cmd.lat_cnt   = (ld_fld == 2'd2);
          cmd.ld_psc    = (ld_fld == 2'd3);
        end
        TGT_MODE: cmd.wr_mode = 1'b1;
        TGT_IO:   cmd.wr_io   = 1'b1;
        TGT_IDX:  cmd.wr_idx  = 1'b1;
        default:  cmd = '0;
      endcase
    end
  end

endmodule

// File: rtl/cfe_byte_ptr.sv
module cfe_byte_ptr #(
  parameter int NBYTES = 3,
  localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (clr)     ptr <= '0;
    else if (step)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R8 / R9: pointer never leaves the byte range
  a_r8_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);

  // R3: pointer reset command lands on byte 0
  a_r3_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr == '0);

endmodule

// File: rtl/cfe_byte_regs.sv
module cfe_byte_regs #(
  parameter int DATA_W = 8,
  parameter int NBYTES = 3,
  localparam int CNT_W = DATA_W * NBYTES,
  localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              lat_en,
  input  logic [CNT_W-1:0]  lat_val,
  input  logic              psc_ld,
  output logic [CNT_W-1:0]  preset,
  output logic [CNT_W-1:0]  latch,
  output logic [DATA_W-1:0] rd_byte,
  output logic [DATA_W-1:0] psc
);

  logic [DATA_W-1:0] lat_bytes [NBYTES];

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        preset[b*DATA_W +: DATA_W] <= '0;
      end else if (wr_en && (ptr == PTR_W'(b))) begin
        preset[b*DATA_W +: DATA_W] <= wr_byte;
      end
    end
    assign lat_bytes[b] = latch[b*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      latch <= '0;
    else if (lat_en) latch <= lat_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psc <= '0;
    else if (psc_ld) psc <= preset[DATA_W-1:0];
  end

  always_comb begin
    rd_byte = lat_bytes[0];
    for (int b = 0; b < NBYTES; b++) begin
      if (ptr == PTR_W'(b)) rd_byte = lat_bytes[b];
    end
  end

  // R7: prescaler takes the low preset byte present at the load edge
  a_r7_psc_load: assert property (@(posedge clk) disable iff (!rst_n)
    psc_ld |=> psc == $past(preset[DATA_W-1:0]));

  // R6: latch captures the live count only on command
  a_r6_latch_capture: assert property (@(posedge clk) disable iff (!rst_n)
    lat_en |=> latch == $past(lat_val));

  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_en |=> $stable(latch));

endmodule

// File: rtl/cnt_byte_fe.sv
module cnt_byte_fe
  import cnt_fe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NBYTES = 3,
  localparam int CNT_W = DATA_W * NBYTES,
  localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic              host_ctl,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [CNT_W-1:0]  core_count,
  input  logic [3:0]        core_flags,
  input  logic              core_err,
  input  logic              core_up,
  output logic [CNT_W-1:0]  preset,
  output logic [DATA_W-1:0] psc,
  output logic              load_cnt,
  output logic              clr_flags,
  output logic              clr_err,
  output logic [CFG_W-1:0]  mode_cfg,
  output logic [CFG_W-1:0]  io_cfg,
  output logic [CFG_W-1:0]  idx_cfg
);

  logic acc, ctl_wr, dat_wr, dat_rd, ctl_rd;
  ctl_cmd_t cmd;
  logic [PTR_W-1:0]  ptr;
  logic [CNT_W-1:0]  latch;
  logic [DATA_W-1:0] rd_byte;
  logic [DATA_W-1:0] status_byte;

  assign host_ready = !rsp_valid;
  assign acc    = host_valid && host_ready;
  assign ctl_wr = acc &&  host_write &&  host_ctl;
  assign dat_wr = acc &&  host_write && !host_ctl;
  assign dat_rd = acc && !host_write && !host_ctl;
  assign ctl_rd = acc && !host_write &&  host_ctl;

  assign status_byte = DATA_W'({core_up, core_err, core_flags});

  cfe_ctl_decode #(.DATA_W(DATA_W)) u_dec (
    .en    (ctl_wr),
    .cbyte (host_wdata),
    .cmd   (cmd)
  );

  cfe_byte_ptr #(.NBYTES(NBYTES)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cmd.ptr_clr),
    .step  (dat_wr || dat_rd),
    .ptr   (ptr)
  );

  cfe_byte_regs #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ptr     (ptr),
    .wr_en   (dat_wr),
    .wr_byte (host_wdata),
    .lat_en  (cmd.lat_cnt),
    .lat_val (core_count),
    .psc_ld  (cmd.ld_psc),
    .preset  (preset),
    .latch   (latch),
    .rd_byte (rd_byte),
    .psc     (psc)
  );

  // Command pulses, one cycle after the accepted write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_cnt  <= 1'b0;
      clr_flags <= 1'b0;
      clr_err   <= 1'b0;
    end else begin
      load_cnt  <= cmd.ld_cnt;
      clr_flags <= cmd.clr_flags;
      clr_err   <= cmd.clr_err;
    end
  end

  // Configuration fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cfg <= '0;
      io_cfg   <= '0;
      idx_cfg  <= '0;
    end else begin
      if (cmd.wr_mode) mode_cfg <= host_wdata[CFG_W-1:0];
      if (cmd.wr_io)   io_cfg   <= host_wdata[CFG_W-1:0];
      if (cmd.wr_idx)  idx_cfg  <= host_wdata[CFG_W-1:0];
    end
  end

  // Read response channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (dat_rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_byte;
    end else if (ctl_rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= status_byte;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R11: a stalled response holds
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R12: configuration writes never act as commands
  a_r12_no_cmd_side: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && (host_wdata[SEL_HI:SEL_LO] != 2'd0)
      |=> !load_cnt && !clr_flags && !clr_err && $stable(psc));

  // R4: the two clear pulses are never high together
  a_r4_clr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_flags, clr_err}));

  // R5: load pulse follows an accepted command write
  a_r5_load_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_cnt) |-> $past(ctl_wr));

endmodule

// File: tb/tb_cnt_byte_fe.sv
module tb_cnt_byte_fe;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic        host_write = 1'b0;
  logic        host_ctl = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_data;
  logic [23:0] core_count = 24'hABCDEF;
  logic [3:0]  core_flags = 4'h5;
  logic        core_err = 1'b1;
  logic        core_up = 1'b1;
  logic [23:0] preset;
  logic [7:0]  psc;
  logic        load_cnt, clr_flags, clr_err;
  logic [4:0]  mode_cfg, io_cfg, idx_cfg;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cnt_byte_fe dut (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_ctl(host_ctl), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .core_count(core_count), .core_flags(core_flags), .core_err(core_err),
    .core_up(core_up), .preset(preset), .psc(psc), .load_cnt(load_cnt),
    .clr_flags(clr_flags), .clr_err(clr_err),
    .mode_cfg(mode_cfg), .io_cfg(io_cfg), .idx_cfg(idx_cfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit ctl, input logic [7:0] b);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_ctl = ctl; host_wdata = b;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic rd(input bit ctl, output logic [7:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_ctl = ctl;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    d = rsp_data;
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
  endtask

  // op: 0 data write, 1 control write, 2 data read, 3 control read
  // fields: op[21:20] byte[19:12] expected[11:4] requirement[3:0]
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {2'd1, 8'h01, 8'h00, 4'd3},   // R3 reset pointer
    {2'd0, 8'h56, 8'h00, 4'd8},   // R8 preset byte 0
    {2'd0, 8'h34, 8'h00, 4'd8},
    {2'd0, 8'h12, 8'h00, 4'd8},
    {2'd1, 8'h11, 8'h00, 4'd6},   // R6 reset pointer and latch count
    {2'd2, 8'h00, 8'hEF, 4'd9},   // R9 LSB first
    {2'd2, 8'h00, 8'hCD, 4'd9},
    {2'd2, 8'h00, 8'hAB, 4'd9},
    {2'd2, 8'h00, 8'hEF, 4'd9},   // R9 wrap
    {2'd1, 8'h01, 8'h00, 4'd3},
    {2'd2, 8'h00, 8'hEF, 4'd3},   // R3 pointer back at byte 0
    {2'd3, 8'h00, 8'h35, 4'd10},  // R10 status byte
    {2'd1, 8'h01, 8'h00, 4'd3},
    {2'd2, 8'h00, 8'hEF, 4'd6}
  };

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] first;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 preset", preset, 0);
    chk("R1 psc", psc, 0);
    chk("R1 cfg", {mode_cfg, io_cfg, idx_cfg}, 0);
    chk("R1 pulses", {load_cnt, clr_flags, clr_err}, 0);
    chk("R1 handshake", {rsp_valid, host_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, d);
    chk("R1 latch zero", d, 8'h00);
    wr(1'b1, 8'h01);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][21:20];
      case (op)
        2'd0: wr(1'b0, VEC[i][19:12]);
        2'd1: wr(1'b1, VEC[i][19:12]);
        2'd2: begin
          rd(1'b0, d);
          chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), d, VEC[i][11:4]);
        end
        default: begin
          rd(1'b1, d);
          chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), d, VEC[i][11:4]);
        end
      endcase
    end
    chk("R8 preset assembled", preset, 24'h123456);

    // R5 load pulse, one cycle wide
    wr(1'b1, 8'h08);
    chk("R5 load pulse", load_cnt, 1'b1);
    @(negedge clk);
    chk("R5 load drop", load_cnt, 1'b0);

    // R8 wrap on writes
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h77); wr(1'b0, 8'h88); wr(1'b0, 8'h99); wr(1'b0, 8'hAA);
    chk("R8 write wrap", preset, 24'h9988AA);

    // R7 prescaler
    wr(1'b1, 8'h18);
    chk("R7 psc", psc, 8'hAA);

    // R4 clear pulses
    wr(1'b1, 8'h04);
    chk("R4 clr_flags", {clr_flags, clr_err}, 2'b10);
    @(negedge clk);
    chk("R4 clr_flags drop", clr_flags, 1'b0);
    wr(1'b1, 8'h06);
    chk("R4 clr_err", {clr_flags, clr_err}, 2'b01);
    wr(1'b1, 8'h02);
    chk("R4 no clear", {clr_flags, clr_err}, 2'b00);

    // R2 / R12 configuration writes
    wr(1'b1, 8'h3F);
    chk("R2 mode", mode_cfg, 5'h1F);
    chk("R12 no pulse", {load_cnt, clr_flags, clr_err}, 0);
    chk("R12 psc kept", psc, 8'hAA);
    wr(1'b1, 8'h4A);
    chk("R2 io", io_cfg, 5'h0A);
    chk("R2 mode kept", mode_cfg, 5'h1F);
    wr(1'b1, 8'h75);
    chk("R2 idx", idx_cfg, 5'h15);
    chk("R2 io kept", io_cfg, 5'h0A);
    // R12 pointer kept at byte 1; R6 latch ignores a changed live count
    core_count = 24'h111111;
    rd(1'b0, d);
    chk("R12 R6 pointer and latch kept", d, 8'hCD);

    // R11 stalled response
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_ctl = 1'b0;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    first = rsp_data;
    chk("R11 first data", first, 8'hAB);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 hold", {rsp_valid, host_ready, rsp_data}, {2'b10, first});
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
    @(negedge clk);
    chk("R11 release", {rsp_valid, host_ready}, 2'b01);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule